// File: doc/BRIEF.md
# Serial Flash Status and Write-Enable Controller

This block keeps the status word of a serial flash device and decides whether each state-changing command may proceed. The command decoder gives it one strobe per decoded instruction. It also receives the write-protect pin level, the data word of a status write, a "target protected" flag from the address protection decode, and a pulse that marks the end of an internal program, erase or status-write cycle. It drives the write-enable latch and the busy flag. In the same cycle as each strobe, it returns a start grant for program/erase, a start grant for a non-volatile status write, and a grant for array reads.

Two copies of the writable status bits are held. The non-volatile copy survives a power cycle. The volatile copy is what the device reads out and what its other logic uses. A status write enabled through the write-enable latch updates both copies and runs a timed cycle. A status write enabled through the separate volatile arming command updates only the volatile copy. It takes no time and leaves the latch alone. A power-up pulse copies the non-volatile bits into the volatile copy and clears the latch, the arming and the busy flag. The lock bits and the second protect bit are one-time programmable and can only be set.

Top module: `sfl_status_ctrl`

## Requirements
- R1: After the asynchronous reset the 16-bit status word reads 0x0000 and every grant output is low.
- R2: The write-enable strobe sets the latch (status bit 1). The write-disable strobe clears it.
- R3: A program/erase strobe while the latch is 0 gives no start grant, and BUSY (status bit 0) stays 0.
- R4: A program/erase strobe with the latch at 1, BUSY at 0 and an unprotected target raises start_modify in the same cycle. BUSY reads 1 from the next cycle while the latch stays 1.
- R5: A program/erase strobe with target_prot high gives no grant and leaves the latch and BUSY unchanged.
- R6: An op_done pulse while busy clears BUSY and the latch together on the next edge.
- R7: While BUSY is 1, read_grant stays low, and the write-enable, write-disable, status-write and program/erase strobes have no effect.
- R8: After the volatile-arm strobe, one status write changes only the volatile copy: no start_wrsr, no BUSY, and the latch is not set. A power-up pulse then restores the non-volatile value.
- R9: The write-disable strobe cancels a pending volatile arming, so a later status write with the latch at 0 changes nothing.
- R10: A status write with the latch at 1 raises start_wrsr and sets BUSY. The written bits persist through a power-up pulse.
- R11: The one-time lock bits (status bits 10 to 13) and the second protect bit (bit 8) never go from 1 to 0 through a status write, whether volatile or non-volatile.
- R12: While bit 8 is 0 and bit 7 is 1, a status write is refused when wp_n is low and accepted when wp_n is high.
- R13: With BUSY at 0, a read strobe raises read_grant in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset to factory state, active low |
| pwr_up | input | 1 | Power-up pulse: reload the volatile copy from the non-volatile copy |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wren_vol | input | 1 | Volatile status-write arming strobe |
| cmd_wrdis | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_modify | input | 1 | Program or erase strobe |
| cmd_read | input | 1 | Array read strobe |
| target_prot | input | 1 | Addressed region is protected |
| wp_n | input | 1 | Write-protect pin level |
| wrsr_data | input | 16 | Status value to write |
| op_done | input | 1 | End of internal cycle |
| status_o | output | 16 | Visible status word |
| start_modify | output | 1 | Program/erase may start |
| start_wrsr | output | 1 | Non-volatile status write starts |
| read_grant | output | 1 | Array read may proceed |

## Verification
The status write is tried four ways: with the latch set, with only volatile arming, with neither, and with hardware protection active at both wp_n levels. These show the non-volatile path, the volatile path and refusal apart, and a power-up pulse after each shows which copy was written. The program/erase strobe is tried with the latch clear, with a protected target, with a clean start, and again while busy. This shows refusal by latch, refusal by protection and the one legal start. Attempts to clear lock bits through both write paths show that the one-time bits are sticky.

// File: rtl/sfl_status_pkg.sv
package sfl_status_pkg;
   localparam int          SR_W     = 16;
   localparam int          B_BUSY   = 0;
   localparam int          B_WEL    = 1;
   localparam int          B_SRP0   = 7;
   localparam int          B_SRP1   = 8;
   // bits software may write: everything except BUSY, WEL and the suspend flag
   localparam logic [15:0] WR_MASK  = 16'h7FFC;
   // one-time bits: second protect bit and the four lock bits
   localparam logic [15:0] OTP_MASK = 16'h3D00;
endpackage

// File: rtl/sfl_wel_ctrl.sv
module sfl_wel_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_up,
   input  logic busy,
   input  logic op_done,
   input  logic wren,
   input  logic wren_vol,
   input  logic wrdis,
   input  logic vol_used,
   output logic wel,
   output logic vol_arm
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel     <= 1'b0;
         vol_arm <= 1'b0;
      end else if (pwr_up) begin
         wel     <= 1'b0;
         vol_arm <= 1'b0;
      end else if (busy) begin
         if (op_done) wel <= 1'b0;
      end else begin
         if (wrdis)     wel <= 1'b0;
         else if (wren) wel <= 1'b1;
         if (wrdis || wren || vol_used) vol_arm <= 1'b0;
         else if (wren_vol)             vol_arm <= 1'b1;
      end
   end
endmodule

// File: rtl/sfl_busy_trk.sv
module sfl_busy_trk (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_up,
   input  logic start,
   input  logic op_done,
   output logic busy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                busy <= 1'b0;
      else if (pwr_up)           busy <= 1'b0;
      else if (busy && op_done)  busy <= 1'b0;
      else if (start)            busy <= 1'b1;
   end
endmodule

// File: rtl/sfl_status_regs.sv
module sfl_status_regs
   import sfl_status_pkg::*;
#(
   parameter int          W        = SR_W,
   parameter logic [15:0] WMASK    = WR_MASK,
   parameter logic [15:0] OMASK    = OTP_MASK,
   parameter bit          STICKY   = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pwr_up,
   input  logic         nv_wr,
   input  logic         vol_wr,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] vol_bits
);
   logic [W-1:0] nv_q, vol_q, nv_next, vol_next;

   generate
      if (STICKY) begin : g_sticky
         assign nv_next  = WMASK[W-1:0] & ((wr_data & ~OMASK[W-1:0]) |
                                           ((wr_data | nv_q) & OMASK[W-1:0]));
         assign vol_next = WMASK[W-1:0] & ((wr_data & ~OMASK[W-1:0]) |
                                           ((wr_data | vol_q) & OMASK[W-1:0]));
      end else begin : g_plain
         assign nv_next  = WMASK[W-1:0] & wr_data;
         assign vol_next = WMASK[W-1:0] & wr_data;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nv_q  <= '0;
         vol_q <= '0;
      end else if (pwr_up) begin
         vol_q <= nv_q;
      end else if (nv_wr) begin
         nv_q  <= nv_next;
         vol_q <= vol_next;
      end else if (vol_wr) begin
         vol_q <= vol_next;
      end
   end

   assign vol_bits = vol_q;
endmodule

// File: rtl/sfl_status_ctrl.sv
module sfl_status_ctrl
   import sfl_status_pkg::*;
#(
   parameter int W            = SR_W,
   parameter bit STICKY_LOCKS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pwr_up,
   input  logic         cmd_wren,
   input  logic         cmd_wren_vol,
   input  logic         cmd_wrdis,
   input  logic         cmd_wrsr,
   input  logic         cmd_modify,
   input  logic         cmd_read,
   input  logic         target_prot,
   input  logic         wp_n,
   input  logic [W-1:0] wrsr_data,
   input  logic         op_done,
   output logic [W-1:0] status_o,
   output logic         start_modify,
   output logic         start_wrsr,
   output logic         read_grant
);
   localparam int IDX_W = $clog2(W);

   generate
      if (W != 16) begin : g_bad_width
         $error("sfl_status_ctrl: status width must be 16");
      end
   endgenerate

   logic         wel, vol_arm, busy;
   logic         sr_open, nv_wr, vol_wr, mod_ok;
   logic [W-1:0] vol_bits;
   logic [IDX_W-1:0] srp0_idx, srp1_idx;

   assign srp0_idx = IDX_W'(B_SRP0);
   assign srp1_idx = IDX_W'(B_SRP1);

   // hardware protection: bit 8 locks outright, bit 7 defers to the pin
   assign sr_open = !vol_bits[srp1_idx] && !(vol_bits[srp0_idx] && !wp_n);
   assign vol_wr  = cmd_wrsr && !busy && !pwr_up && vol_arm && sr_open;
   assign nv_wr   = cmd_wrsr && !busy && !pwr_up && !vol_arm && wel && sr_open;
   assign mod_ok  = cmd_modify && !busy && !pwr_up && wel && !target_prot;

   sfl_wel_ctrl i_wel (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_up   (pwr_up),
      .busy     (busy),
      .op_done  (op_done),
      .wren     (cmd_wren),
      .wren_vol (cmd_wren_vol),
      .wrdis    (cmd_wrdis),
      .vol_used (vol_wr),
      .wel      (wel),
      .vol_arm  (vol_arm)
   );

   sfl_busy_trk i_busy (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwr_up  (pwr_up),
      .start   (mod_ok || nv_wr),
      .op_done (op_done),
      .busy    (busy)
   );

   sfl_status_regs #(
      .W      (W),
      .STICKY (STICKY_LOCKS)
   ) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_up   (pwr_up),
      .nv_wr    (nv_wr),
      .vol_wr   (vol_wr),
      .wr_data  (wrsr_data),
      .vol_bits (vol_bits)
   );

   always_comb begin
      status_o         = vol_bits;
      status_o[B_BUSY] = busy;
      status_o[B_WEL]  = wel;
   end

   assign start_modify = mod_ok;
   assign start_wrsr   = nv_wr;
   assign read_grant   = cmd_read && !busy;
endmodule

// File: rtl/sfl_status_ctrl_chk.sv
module sfl_status_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        pwr_up,
   input logic        cmd_wren,
   input logic        cmd_wren_vol,
   input logic        cmd_read,
   input logic        target_prot,
   input logic        op_done,
   input logic [15:0] status_o,
   input logic        start_modify,
   input logic        start_wrsr,
   input logic        read_grant
);
   localparam logic [15:0] LOCKS = 16'h3D00;

   AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      start_modify |-> (status_o[1] && !status_o[0])); // R3
   AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      target_prot |-> !start_modify); // R5
   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      ((start_modify || start_wrsr) && !op_done) |=> (status_o[0] || $past(pwr_up) || pwr_up)); // R4
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_done && status_o[0]) |=> (!status_o[0] && !status_o[1])); // R6
   AST_NO_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_read && status_o[0]) |-> !read_grant); // R7
   AST_LOCKS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_up |=> ((status_o & LOCKS & $past(status_o)) == ($past(status_o) & LOCKS))); // R11
   AST_VOL_NO_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wren_vol && !cmd_wren && !status_o[1]) |=> !status_o[1]); // R8
endmodule

bind sfl_status_ctrl sfl_status_ctrl_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pwr_up       (pwr_up),
   .cmd_wren     (cmd_wren),
   .cmd_wren_vol (cmd_wren_vol),
   .cmd_read     (cmd_read),
   .target_prot  (target_prot),
   .op_done      (op_done),
   .status_o     (status_o),
   .start_modify (start_modify),
   .start_wrsr   (start_wrsr),
   .read_grant   (read_grant)
);

// File: tb/test_sfl_status_ctrl.sv
module test_sfl_status_ctrl;
   localparam int CLK_PERIOD = 10;

   localparam logic [3:0] OP_WREN = 4'd1, OP_WVOL = 4'd2, OP_WDIS = 4'd3,
                          OP_WRSR = 4'd4, OP_MOD = 4'd5, OP_DONE = 4'd6,
                          OP_READ = 4'd7, OP_PWR = 4'd8;

   typedef struct packed {
      logic [3:0]  op;
      logic [15:0] data;
      logic        prot;
      logic        wp;
      logic [15:0] exp_st;
      logic [2:0]  exp_g;   // {start_modify, start_wrsr, read_grant}
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 30;
   localparam vec_t VECS [NV] = '{
      '{OP_READ, 16'h0000, 1'b0, 1'b1, 16'h0000, 3'b001, 8'd13}, // R13
      '{OP_MOD,  16'h0000, 1'b0, 1'b1, 16'h0000, 3'b000, 8'd3 }, // R3
      '{OP_WREN, 16'h0000, 1'b0, 1'b1, 16'h0002, 3'b000, 8'd2 }, // R2
      '{OP_MOD,  16'h0000, 1'b1, 1'b1, 16'h0002, 3'b000, 8'd5 }, // R5
      '{OP_MOD,  16'h0000, 1'b0, 1'b1, 16'h0003, 3'b100, 8'd4 }, // R4
      '{OP_READ, 16'h0000, 1'b0, 1'b1, 16'h0003, 3'b000, 8'd7 }, // R7
      '{OP_WDIS, 16'h0000, 1'b0, 1'b1, 16'h0003, 3'b000, 8'd7 }, // R7
      '{OP_DONE, 16'h0000, 1'b0, 1'b1, 16'h0000, 3'b000, 8'd6 }, // R6
      '{OP_WREN, 16'h0000, 1'b0, 1'b1, 16'h0002, 3'b000, 8'd2 }, // R2
      '{OP_WDIS, 16'h0000, 1'b0, 1'b1, 16'h0000, 3'b000, 8'd2 }, // R2
      '{OP_WREN, 16'h0000, 1'b0, 1'b1, 16'h0002, 3'b000, 8'd10}, // R10
      '{OP_WRSR, 16'h0C1C, 1'b0, 1'b1, 16'h0C1F, 3'b010, 8'd10}, // R10
      '{OP_DONE, 16'h0000, 1'b0, 1'b1, 16'h0C1C, 3'b000, 8'd6 }, // R6
      '{OP_WVOL, 16'h0000, 1'b0, 1'b1, 16'h0C1C, 3'b000, 8'd8 }, // R8
      '{OP_WRSR, 16'h0020, 1'b0, 1'b1, 16'h0C20, 3'b000, 8'd8 }, // R8 and R11
      '{OP_PWR,  16'h0000, 1'b0, 1'b1, 16'h0C1C, 3'b000, 8'd8 }, // R8 restore
      '{OP_WVOL, 16'h0000, 1'b0, 1'b1, 16'h0C1C, 3'b000, 8'd9 }, // R9
      '{OP_WDIS, 16'h0000, 1'b0, 1'b1, 16'h0C1C, 3'b000, 8'd9 }, // R9
      '{OP_WRSR, 16'h0000, 1'b0, 1'b1, 16'h0C1C, 3'b000, 8'd9 }, // R9
      '{OP_WREN, 16'h0000, 1'b0, 1'b1, 16'h0C1E, 3'b000, 8'd2 }, // R2
      '{OP_WRSR, 16'h0080, 1'b0, 1'b1, 16'h0C83, 3'b010, 8'd12}, // R12
      '{OP_DONE, 16'h0000, 1'b0, 1'b1, 16'h0C80, 3'b000, 8'd6 }, // R6
      '{OP_WREN, 16'h0000, 1'b0, 1'b0, 16'h0C82, 3'b000, 8'd12}, // R12
      '{OP_WRSR, 16'h0000, 1'b0, 1'b0, 16'h0C82, 3'b000, 8'd12}, // R12 refused
      '{OP_WRSR, 16'h0004, 1'b0, 1'b1, 16'h0C07, 3'b010, 8'd12}, // R12 accepted
      '{OP_DONE, 16'h0000, 1'b0, 1'b1, 16'h0C04, 3'b000, 8'd6 }, // R6
      '{OP_WREN, 16'h0000, 1'b0, 1'b1, 16'h0C06, 3'b000, 8'd11}, // R11
      '{OP_WRSR, 16'h0000, 1'b0, 1'b1, 16'h0C03, 3'b010, 8'd11}, // R11
      '{OP_DONE, 16'h0000, 1'b0, 1'b1, 16'h0C00, 3'b000, 8'd11}, // R11
      '{OP_PWR,  16'h0000, 1'b0, 1'b1, 16'h0C00, 3'b000, 8'd11}  // R11
   };

   logic        clk = 1'b0;
   logic        rst_n, pwr_up, cmd_wren, cmd_wren_vol, cmd_wrdis, cmd_wrsr;
   logic        cmd_modify, cmd_read, target_prot, wp_n, op_done;
   logic [15:0] wrsr_data, status_o;
   logic        start_modify, start_wrsr, read_grant;
   int          n_chk = 0, n_fail = 0, cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sfl_status_ctrl i_sfl_status_ctrl (
      .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .cmd_wren(cmd_wren),
      .cmd_wren_vol(cmd_wren_vol), .cmd_wrdis(cmd_wrdis), .cmd_wrsr(cmd_wrsr),
      .cmd_modify(cmd_modify), .cmd_read(cmd_read), .target_prot(target_prot),
      .wp_n(wp_n), .wrsr_data(wrsr_data), .op_done(op_done),
      .status_o(status_o), .start_modify(start_modify),
      .start_wrsr(start_wrsr), .read_grant(read_grant));

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_in();
      pwr_up = 0; cmd_wren = 0; cmd_wren_vol = 0; cmd_wrdis = 0; cmd_wrsr = 0;
      cmd_modify = 0; cmd_read = 0; op_done = 0; target_prot = 0; wrsr_data = '0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=<5000", cyc);
         finish_run();
      end
   end

   initial begin
      idle_in(); wp_n = 1; rst_n = 0;
      repeat (2) @(negedge clk);
      check("R1 status in reset", status_o, 16'h0000);
      rst_n = 1;
      @(negedge clk);
      check("R1 status after reset", status_o, 16'h0000);
      check("R1 grants idle", {13'd0, start_modify, start_wrsr, read_grant}, 16'h0000);

      foreach (VECS[i]) begin
         idle_in();
         wrsr_data = VECS[i].data; target_prot = VECS[i].prot; wp_n = VECS[i].wp;
         case (VECS[i].op)
            OP_WREN: cmd_wren = 1;
            OP_WVOL: cmd_wren_vol = 1;
            OP_WDIS: cmd_wrdis = 1;
            OP_WRSR: cmd_wrsr = 1;
            OP_MOD:  cmd_modify = 1;
            OP_DONE: op_done = 1;
            OP_READ: cmd_read = 1;
            OP_PWR:  pwr_up = 1;
            default: ;
         endcase
         #2;
         check($sformatf("R%0d grants step %0d", VECS[i].req, i),
               {13'd0, start_modify, start_wrsr, read_grant}, {13'd0, VECS[i].exp_g});
         @(negedge clk);
         idle_in();
         check($sformatf("R%0d status step %0d", VECS[i].req, i), status_o, VECS[i].exp_st);
      end

      // R7: while busy, write-enable and status-write are ignored
      wp_n = 1; cmd_wren = 1; @(negedge clk); idle_in();
      cmd_modify = 1; @(negedge clk); idle_in();
      cmd_wrsr = 1; wrsr_data = 16'h001C; #2;
      check("R7 no wrsr start while busy", {15'd0, start_wrsr}, 16'h0000);
      @(negedge clk); idle_in();
      check("R7 status untouched while busy", status_o, 16'h0C03);
      op_done = 1; @(negedge clk); idle_in();
      check("R6 done after busy", status_o, 16'h0C00);

      // R1: asynchronous reset mid-run restores factory state
      #1 rst_n = 0; #1;
      check("R1 async reset", status_o, 16'h0000);
      @(negedge clk); rst_n = 1; @(negedge clk);
      check("R1 after second reset", status_o, 16'h0000);

      finish_run();
   end
endmodule